// File: doc/BRIEF.md
# SPI Transceiver with Write-Collision Detection

A full-duplex serial shift unit for three-wire SPI links. Software (or a bus bridge) configures it through a small register window. The window has a control byte, a read-only status byte and a data port. A write to the data port supplies the next byte to send. A read of the data port returns the last byte received. Every transfer moves exactly one byte in each direction.

In master mode the unit makes the serial clock itself, at one of four rates derived from the system clock. It drives the outgoing line and samples the incoming one. In slave mode it synchronises an external serial clock and follows it. Clock polarity, clock phase and bit order can be chosen. Received bytes are always held in a separate buffer, so software can read the previous byte while the next one shifts in. The transmit side has two modes. In normal mode it has a single buffer and refuses writes while a byte is under way. In enhanced mode one extra byte can be queued. Illegal writes raise a collision flag.

The shift engine is a three-state machine. **IDLE** waits for work. Its transitions are IDLE→SHIFT when a master has a byte to send, or when a slave sees its first clock edge. **SHIFT** counts 16 clock edges and leaves on the 16th through SHIFT→FINISH. **FINISH** lasts one cycle, publishes the received byte and raises the end-of-transfer event, then returns through FINISH→IDLE. Clearing the enable bit forces any state back to IDLE.

Top module: `spi_xcvr`

## Requirements
- R1: Each transfer sends one byte and receives one byte at the same time. After completion, a read of address 2 returns the byte shifted in.
- R2: Control bit 6 selects the role. When it is 1, the unit drives `sck_out` and `mosi_out` and samples `miso_in`. When it is 0, it follows `sck_in`, samples `mosi_in` and drives `miso_out`. Control bit 7 enables the unit; when it is 0, the engine stays in IDLE.
- R3: In master mode, control bits [1:0] = 0, 1, 2, 3 give a serial clock period of 4, 16, 64 and 128 system clocks. The corresponding half periods are 2, 8, 32 and 64.
- R4: Control bit 5 = 1 puts the least significant bit on the wire first. Control bit 5 = 0 puts the most significant bit first.
- R5: Status bit 7 (end of transfer) is set after the 16th serial clock edge of a byte.
- R6: The receive buffer keeps its byte until the next transfer finishes. It can therefore be read while a following byte is shifting.
- R7: With control bit 2 = 1 (enhanced), one byte can be written while a transfer runs. Status bit 1 then reads 1, and that byte starts automatically afterwards. A write while that queue is full sets status bit 6 and is dropped.
- R8: With control bit 2 = 0 (normal), a data write while a transfer is pending or running sets status bit 6 (collision). That write is dropped and never transmitted.
- R9: Control bit 4 gives the serial clock's idle level. Control bit 3 = 0 samples on the leading edge and changes data on the trailing edge. Control bit 3 = 1 changes data on the leading edge and samples on the trailing edge.
- R10: Status bits 7 and 6 are cleared by a status read (address 1) followed by a data-port access (address 2). Accesses to other addresses in between do not clear them.
- R11: After reset, the control, status and receive registers read 0, and `sck_out` is low.
- R12: The register addresses are: 0 = control (read/write), 1 = status (read only), 2 = data (write sends, read returns the received byte). Status bit 0 reads 1 while the engine is not IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 2 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data (combinational on reg_addr) |
| sck_in | input | 1 | Serial clock from a remote master |
| sck_out | output | 1 | Serial clock driven in master mode |
| mosi_in | input | 1 | Serial data in, used in slave mode |
| mosi_out | output | 1 | Serial data out, used in master mode |
| miso_in | input | 1 | Serial data in, used in master mode |
| miso_out | output | 1 | Serial data out, used in slave mode |

## Verification
The hardest situation to reach is the enhanced-mode queue. It needs a second byte accepted while the first is shifting, then a third byte refused, then the first received byte read back while the queued byte is already on the wire. The bench gets there by waiting two cycles after the first data write, so the engine has taken the byte and the queue is empty. It then writes twice in a row, and polls status to read the first received byte before the second transfer ends. A bench-side slave model drives a 16-bit pattern across both bytes, so the result also shows that the dropped byte never appeared.

// File: rtl/spi_xcvr_pkg.sv
package spi_xcvr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SHIFT  = 2'd1,
        ST_FINISH = 2'd2
    } eng_state_t;

    // control byte bit positions
    localparam int B_EN   = 7;
    localparam int B_MST  = 6;
    localparam int B_LSB  = 5;
    localparam int B_CPOL = 4;
    localparam int B_CPHA = 3;
    localparam int B_ENH  = 2;
endpackage

// File: rtl/spi_rate_gen.sv
module spi_rate_gen #(
    parameter int BASE_HALF = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [1:0] rate,
    output logic       tick
);
    localparam int CW = $clog2(BASE_HALF * 32);

    logic [CW-1:0] cnt;
    logic [CW-1:0] half_m1;

    always_comb begin
        unique case (rate)
            2'd0:    half_m1 = CW'(BASE_HALF - 1);
            2'd1:    half_m1 = CW'(BASE_HALF * 4 - 1);
            2'd2:    half_m1 = CW'(BASE_HALF * 16 - 1);
            default: half_m1 = CW'(BASE_HALF * 32 - 1);
        endcase
    end

    assign tick = run && (cnt == half_m1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            cnt <= '0;
        else if (!run || tick) cnt <= '0;
        else                   cnt <= cnt + 1'b1;
    end

    // R3
    tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/spi_sck_sync.sv
module spi_sck_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_in,
    output logic sck_edge
);
    logic [2:0] s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s <= '0;
        else        s <= {s[1:0], sck_in};
    end

    assign sck_edge = s[2] ^ s[1];
endmodule

// File: rtl/spi_engine.sv
module spi_engine
    import spi_xcvr_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          master,
    input  logic          lsb_first,
    input  logic          cpha,
    input  logic          edge_ev,
    input  logic          din,
    input  logic          ld_valid,
    input  logic [DW-1:0] ld_data,
    output logic          ld_ready,
    output logic          busy,
    output logic          shifting,
    output logic          done,
    output logic [DW-1:0] rx_data,
    output logic          dout,
    output logic          sck_lvl
);
    localparam int EDGES = 2 * DW;
    localparam int CW    = $clog2(EDGES);

    eng_state_t    state, nxt;
    logic [CW-1:0] ecnt;
    logic [DW-1:0] tx_sh, rx_sh;
    logic          act, sample_now, shift_now, last_edge;

    assign act        = en && edge_ev && (state == ST_SHIFT || (state == ST_IDLE && !master));
    assign sample_now = act && (cpha ? ecnt[0] : !ecnt[0]);
    assign shift_now  = act && (cpha ? (!ecnt[0] && ecnt != '0) : ecnt[0]);
    assign last_edge  = ecnt == CW'(EDGES - 1);

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (!master && edge_ev)      nxt = ST_SHIFT;
                else if (master && ld_valid) nxt = ST_SHIFT;
            end
            ST_SHIFT:  if (edge_ev && last_edge) nxt = ST_FINISH;
            ST_FINISH: nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
        if (!en) nxt = ST_IDLE;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // outputs
    always_comb begin
        busy     = state != ST_IDLE;
        shifting = state == ST_SHIFT;
        done     = state == ST_FINISH;
        ld_ready = en && state == ST_IDLE && !(edge_ev && !master);
        dout     = lsb_first ? tx_sh[0] : tx_sh[DW-1];
        rx_data  = rx_sh;
    end

    // shift datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ecnt    <= '0;
            tx_sh   <= '0;
            rx_sh   <= '0;
            sck_lvl <= 1'b0;
        end else if (!en) begin
            ecnt    <= '0;
            sck_lvl <= 1'b0;
        end else begin
            if (ld_valid && ld_ready) tx_sh <= ld_data;
            if (act) begin
                ecnt <= last_edge ? '0 : ecnt + 1'b1;
                if (master) sck_lvl <= !sck_lvl;
                if (sample_now)
                    rx_sh <= lsb_first ? {din, rx_sh[DW-1:1]} : {rx_sh[DW-2:0], din};
                if (shift_now)
                    tx_sh <= lsb_first ? (tx_sh >> 1) : (tx_sh << 1);
            end
        end
    end

    // R5
    finish_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_FINISH |=> state == ST_IDLE);

    // R9
    idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_IDLE |-> sck_lvl == 1'b0);

    // R2
    no_stray_sck_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (master && state == ST_IDLE) |=> $stable(sck_lvl));
endmodule

// File: rtl/spi_xcvr.sv
module spi_xcvr
    import spi_xcvr_pkg::*;
#(
    parameter int DW        = 8,
    parameter int BASE_HALF = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    reg_addr,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic          sck_in,
    output logic          sck_out,
    input  logic          mosi_in,
    output logic          mosi_out,
    input  logic          miso_in,
    output logic          miso_out
);
    logic [7:0]    ctrl;
    logic [DW-1:0] tx_buf, rx_buf, eng_rx;
    logic          pend, done_f, wcol_f, arm;
    logic          tick, sck_edge, edge_ev, din, dout, sck_lvl;
    logic          ld_ready, busy, shifting, eng_done;
    logic          wr_ctl, rd_st, data_acc, wr_dat, coll;
    logic          master;

    assign master   = ctrl[B_MST];
    assign wr_ctl   = reg_wr && reg_addr == 2'd0;
    assign rd_st    = reg_rd && reg_addr == 2'd1;
    assign wr_dat   = reg_wr && reg_addr == 2'd2;
    assign data_acc = (reg_wr || reg_rd) && reg_addr == 2'd2;
    assign coll     = wr_dat && (ctrl[B_ENH] ? pend : (busy || pend));

    spi_rate_gen #(.BASE_HALF(BASE_HALF)) u_rate (
        .clk(clk), .rst_n(rst_n), .run(master && shifting),
        .rate(ctrl[1:0]), .tick(tick)
    );

    spi_sck_sync u_sync (
        .clk(clk), .rst_n(rst_n), .sck_in(sck_in), .sck_edge(sck_edge)
    );

    assign edge_ev = master ? tick : sck_edge;
    assign din     = master ? miso_in : mosi_in;

    spi_engine #(.DW(DW)) u_eng (
        .clk(clk), .rst_n(rst_n), .en(ctrl[B_EN]), .master(master),
        .lsb_first(ctrl[B_LSB]), .cpha(ctrl[B_CPHA]), .edge_ev(edge_ev),
        .din(din), .ld_valid(pend), .ld_data(tx_buf), .ld_ready(ld_ready),
        .busy(busy), .shifting(shifting), .done(eng_done), .rx_data(eng_rx),
        .dout(dout), .sck_lvl(sck_lvl)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl   <= '0;
            tx_buf <= '0;
            rx_buf <= '0;
            pend   <= 1'b0;
            done_f <= 1'b0;
            wcol_f <= 1'b0;
            arm    <= 1'b0;
        end else begin
            if (wr_ctl) ctrl <= reg_wdata[7:0];
            if (pend && ld_ready) pend <= 1'b0;
            if (wr_dat && !coll) begin
                pend   <= 1'b1;
                tx_buf <= reg_wdata;
            end
            if (data_acc)   arm <= 1'b0;
            else if (rd_st) arm <= 1'b1;
            if (eng_done)              done_f <= 1'b1;
            else if (data_acc && arm)  done_f <= 1'b0;
            if (coll)                  wcol_f <= 1'b1;
            else if (data_acc && arm)  wcol_f <= 1'b0;
            if (eng_done) rx_buf <= eng_rx;
        end
    end

    always_comb begin
        unique case (reg_addr)
            2'd0:    reg_rdata = DW'(ctrl);
            2'd1:    reg_rdata = DW'({done_f, wcol_f, 4'b0000, pend, busy});
            2'd2:    reg_rdata = rx_buf;
            default: reg_rdata = '0;
        endcase
    end

    assign sck_out  = master ? (sck_lvl ^ ctrl[B_CPOL]) : ctrl[B_CPOL];
    assign mosi_out = dout;
    assign miso_out = dout;

    // R8
    coll_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_dat && !ctrl[B_ENH] && busy) |=> (wcol_f && $stable(tx_buf)));

    // R7
    enh_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_dat && ctrl[B_ENH] && pend) |=> (wcol_f && pend));

    // R6
    rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !eng_done |=> $stable(rx_buf));

    // R5
    done_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_done |=> done_f);
endmodule

// File: tb/spi_xcvr_tb.sv
module spi_xcvr_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] reg_addr = '0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0] reg_wdata = '0, reg_rdata;
    logic       sck_in = 1'b0, sck_out, mosi_in = 1'b0, mosi_out, miso_in, miso_out;

    always #10 clk = ~clk;

    spi_xcvr u_dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .sck_in(sck_in), .sck_out(sck_out), .mosi_in(mosi_in),
        .mosi_out(mosi_out), .miso_in(miso_in), .miso_out(miso_out)
    );

    int n_chk = 0, n_fail = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] wire_ord(input logic [7:0] b, input logic lsb);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = lsb ? b[i] : b[7-i];
        return r;
    endfunction

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic wait_done(output logic [7:0] st);
        st = '0;
        for (int i = 0; i < 3000; i++) begin
            rd(2'd1, st);
            if (st[7]) break;
        end
    endtask

    // bench-side slave model for master-mode transfers
    logic mon_on = 1'b0, m_cpha = 1'b0, sck_prev = 1'b0;
    logic sbits [0:32];
    logic obs   [0:31];
    int   n_edge = 0, n_samp = 0, cyc = 0, last_cyc = 0, interval = 0;

    initial for (int i = 0; i < 33; i++) sbits[i] = 1'b0;

    always @(negedge clk) begin
        cyc++;
        if (!mon_on) begin
            n_edge = 0; n_samp = 0; miso_in = sbits[0];
        end else if (sck_out !== sck_prev) begin
            if (n_edge == 1) interval = cyc - last_cyc;
            last_cyc = cyc;
            if (m_cpha ? n_edge[0] : !n_edge[0]) begin
                obs[n_samp] = mosi_out;
                n_samp++;
                miso_in = sbits[n_samp];
            end
            n_edge++;
        end
        sck_prev = sck_out;
    end

    task automatic set_sbits(input logic [7:0] w0, input logic [7:0] w1);
        for (int i = 0; i < 8; i++) begin
            sbits[i] = w0[i];
            sbits[i+8] = w1[i];
        end
    endtask

    task automatic mxfer(input logic cp, input logic ph, input logic lsb,
                         input logic [1:0] rt, input logic [7:0] t, input logic [7:0] s);
        logic [7:0] st, rx, ob;
        int half;
        mon_on = 1'b0;
        m_cpha = ph;
        set_sbits(wire_ord(s, lsb), 8'h00);
        wr(2'd0, {1'b1, 1'b1, lsb, cp, ph, 1'b0, rt});
        @(negedge clk); mon_on = 1'b1; @(negedge clk);
        wr(2'd2, t);
        wait_done(st);
        rd(2'd2, rx);
        half = (rt == 2'd3) ? 64 : (2 << (2 * rt));
        for (int i = 0; i < 8; i++) ob[i] = obs[i];
        chk("R5 master end-of-transfer flag", 32'(st[7]), 32'd1);
        chk("R1 master received byte", 32'(rx), 32'(s));
        chk("R4 master wire bit order", 32'(ob), 32'(wire_ord(t, lsb)));
        chk("R3 master half period", 32'(interval), 32'(half));
        chk("R9 master idle clock level", 32'(sck_out), 32'(cp));
    endtask

    task automatic sxfer(input logic cp, input logic ph, input logic lsb,
                         input logic [7:0] t, input logic [7:0] m);
        logic [7:0] w, mb, st, rx;
        mon_on = 1'b0;
        w = wire_ord(m, lsb);
        mb = '0;
        wr(2'd0, 8'h00);
        sck_in = cp; mosi_in = w[0];
        repeat (4) @(negedge clk);
        wr(2'd0, {1'b1, 1'b0, lsb, cp, ph, 3'b000});
        wr(2'd2, t);
        repeat (3) @(negedge clk);
        for (int e = 0; e < 16; e++) begin
            repeat (6) @(negedge clk);
            if (ph ? e[0] : !e[0]) mb[e/2] = miso_out;
            sck_in = ~sck_in;
            if (!ph && e[0] && e < 15) mosi_in = w[(e+1)/2];
            if (ph && !e[0] && e > 0)  mosi_in = w[e/2];
        end
        repeat (8) @(negedge clk);
        rd(2'd1, st);
        rd(2'd2, rx);
        chk("R5 slave end-of-transfer flag", 32'(st[7]), 32'd1);
        chk("R2 slave received byte from mosi_in", 32'(rx), 32'(m));
        chk("R4 slave miso bit order", 32'(mb), 32'(wire_ord(t, lsb)));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired (all requirements) actual=hung expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [7:0] d, st, rx, ob;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 reset state
        rd(2'd0, d); chk("R11 control after reset", 32'(d), 32'd0);
        rd(2'd1, d); chk("R11 status after reset", 32'(d), 32'd0);
        rd(2'd2, d); chk("R11 rx after reset", 32'(d), 32'd0);
        chk("R11 sck_out after reset", 32'(sck_out), 32'd0);

        // R12 control readback
        wr(2'd0, 8'h5A); rd(2'd0, d);
        chk("R12 control readback", 32'(d), 32'h5A);
        wr(2'd0, 8'h00);

        // R1 R3 R4 R9: master sweep over every polarity, phase, order and rate
        for (int c = 0; c < 32; c++) begin
            logic [7:0] t, s;
            t = 8'(8'hA5 ^ (c * 37));
            s = 8'(8'h3C + c * 53);
            mxfer(c[4], c[3], c[2], c[1:0], t, s);
        end

        // R2 R4: slave sweep
        for (int c = 0; c < 8; c++) begin
            sxfer(c[2], c[1], c[0], 8'(8'hC6 + c * 29), 8'(8'h1B ^ (c * 71)));
        end

        // R8 normal-mode write collision, R10 flag clearing
        mon_on = 1'b0; m_cpha = 1'b0;
        set_sbits(8'h00, 8'h00);
        wr(2'd0, 8'hC0);
        @(negedge clk); mon_on = 1'b1; @(negedge clk);
        wr(2'd2, 8'h96);
        wr(2'd2, 8'h0F);
        rd(2'd1, st);
        chk("R8 collision flag on busy write", 32'(st[6]), 32'd1);
        wait_done(st);
        for (int i = 0; i < 8; i++) ob[i] = obs[i];
        chk("R8 dropped write not transmitted", 32'(ob), 32'(wire_ord(8'h96, 1'b0)));
        wr(2'd0, 8'hC0);
        rd(2'd1, st);
        chk("R10 flags kept across control access", 32'(st[7:6]), 32'h3);
        rd(2'd2, d);
        rd(2'd1, st);
        chk("R10 flags cleared and R8 no second transfer", 32'(st), 32'd0);

        // R7 enhanced queue, R6 receive double buffer
        mon_on = 1'b0; m_cpha = 1'b0;
        set_sbits(wire_ord(8'h81, 1'b1), wire_ord(8'h7E, 1'b1));
        wr(2'd0, 8'hE5);
        @(negedge clk); mon_on = 1'b1; @(negedge clk);
        wr(2'd2, 8'h4D);
        repeat (2) @(negedge clk);
        wr(2'd2, 8'hB2);
        rd(2'd1, st);
        chk("R7 queued byte accepted without collision", 32'(st[6]), 32'd0);
        chk("R7 queue full bit", 32'(st[1]), 32'd1);
        wr(2'd2, 8'hFF);
        rd(2'd1, st);
        chk("R7 collision on full queue", 32'(st[6]), 32'd1);
        wait_done(st);
        rd(2'd2, rx);
        rd(2'd1, st);
        chk("R6 first byte readable during next transfer", 32'(rx), 32'h81);
        chk("R7 queued byte started automatically", 32'(st[0]), 32'd1);
        wait_done(st);
        rd(2'd2, rx);
        chk("R6 second received byte", 32'(rx), 32'h7E);
        for (int i = 0; i < 8; i++) ob[i] = obs[i];
        chk("R7 first wire byte", 32'(ob), 32'(wire_ord(8'h4D, 1'b1)));
        for (int i = 0; i < 8; i++) ob[i] = obs[i+8];
        chk("R7 queued wire byte, dropped byte absent", 32'(ob), 32'(wire_ord(8'hB2, 1'b1)));

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule